// File: doc/BRIEF.md
# Peripheral Bus Request Reply Formatter

This block takes a host command packet that has already been collected into a local byte buffer and decides what to do with it. An ordinary request is checked for a consistent payload length. It is then forwarded, one byte per cycle, to a transaction port that talks to an attached serial peripheral bus. When the bus side reports its result, the block assembles a reply buffer: a success marker, a length prefix and the returned bytes. It announces the finished reply with a single-cycle event. The host reads the reply through a simple registered read port when it acknowledges the interrupt.

One fixed key pair in the first two bytes marks a packet as a local autopoll-configuration request. Such a packet is never forwarded and produces no reply. Its two following bytes update the autopoll mask and enable. While the host is in the middle of a command, a new request waits and autopolling is held off, so the reply buffer the host may be reading is left untouched.

Top module: `bus_reply_fmt`

## Requirements
- R1: A packet of length 0 or 1 produces no reply event and no transaction, and the reply size stays as it was.
- R2: A packet whose byte 0 is 0x00 and byte 1 is 0x86, with length exactly 4, is handled locally. It writes the mask {byte 2, byte 3} (byte 2 in bits 15:8), forwards nothing and raises no reply event.
- R3: A packet with the 0x00/0x86 key pair and a length other than 4 is discarded: the mask, the enable and the reply size stay unchanged and no event is raised.
- R4: A local mask write with a non-zero value loads ap_mask and sets ap_enable. A zero value clears ap_enable and keeps ap_mask.
- R5: For any other packet of length at least 2, byte 2 is the payload count. A length below 3, a count above length minus 3, or a count above 252 is a failure, and nothing is forwarded.
- R6: A valid request is forwarded as byte 0 followed by bytes 3 through length-1, one byte per cycle on txn_valid/txn_data, with txn_last on the final byte only.
- R7: A result with a non-zero length N yields the reply 0x01, N, then the N result bytes in arrival order, and a reply size of N+2.
- R8: A failed request, or a result of length 0, yields the single-byte reply 0x00 with a reply size of 1.
- R9: Every packet that is neither rejected by R1 nor matched by R2/R3 produces exactly one rpl_ready pulse of one cycle, after the reply size and content are final.
- R10: A request started while host_busy is high is held until host_busy is low, with no transaction and no reply event in between. poll_run is low in the cycle after any cycle with host_busy high, and otherwise follows ap_enable.
- R11: After reset, rpl_size, ap_mask, ap_enable, poll_run, rpl_ready and txn_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_we | input | 1 | Packet buffer write strobe |
| pkt_waddr | input | 8 | Packet buffer write address |
| pkt_wdata | input | 8 | Packet buffer write byte |
| pkt_len | input | 9 | Packet length, captured with pkt_start |
| pkt_start | input | 1 | Request to process the buffered packet |
| host_busy | input | 1 | Host command in progress |
| txn_valid | output | 1 | Forwarded transaction byte valid |
| txn_data | output | 8 | Forwarded transaction byte |
| txn_last | output | 1 | Final byte of the forwarded transaction |
| res_valid | input | 1 | Result byte valid |
| res_data | input | 8 | Result byte |
| res_done | input | 1 | Transaction finished |
| res_len | input | 8 | Result length, valid with res_done |
| rpl_raddr | input | 9 | Reply buffer read address |
| rpl_rdata | output | 8 | Reply byte, one cycle after the address |
| rpl_size | output | 9 | Reply size in bytes |
| rpl_ready | output | 1 | Reply finished (one-cycle pulse) |
| ap_mask | output | 16 | Autopoll device mask |
| ap_enable | output | 1 | Autopoll enabled |
| poll_run | output | 1 | Autopoll enabled and not held off by the host |

## Verification
The assertions assume a well-behaved bus side. It drives res_valid and res_done only after the block has put out txn_last, raises res_done once per transaction, and keeps res_len equal to the number of result bytes it sent. They also assume that pkt_start is not pulsed while a request is still being worked on. The stimulus keeps within this. Each request is followed until its reply event, or for a fixed quiet window when no event is due, before the next packet is written. The bus responder reacts only to an observed txn_last and sends exactly the bytes it declares.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_H0, ST_H1, ST_H2, ST_H3, ST_H4, ST_DEC,
    ST_TX0, ST_TXB, ST_WAIT, ST_HD0, ST_HD1, ST_FAIL, ST_FIN
  } rrf_state_e;

  localparam logic [7:0] OK_MARK   = 8'h01;
  localparam logic [7:0] FAIL_MARK = 8'h00;
endpackage

// File: rtl/rrf_ram.sv
module rrf_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rrf_autopoll.sv
module rrf_autopoll #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [MW-1:0] wr_mask,
  input  logic          host_busy,
  output logic [MW-1:0] ap_mask,
  output logic          ap_enable,
  output logic          poll_run
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ap_mask   <= '0;
      ap_enable <= 1'b0;
      poll_run  <= 1'b0;
    end else begin
      if (wr) begin
        if (wr_mask != '0) begin
          ap_mask   <= wr_mask;
          ap_enable <= 1'b1;
        end else begin
          ap_enable <= 1'b0;
        end
      end
      poll_run <= ap_enable & ~host_busy;
    end
  end

  // R4
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_mask == '0) |=> (!ap_enable && $stable(ap_mask)));

  // R4
  load_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_mask != '0) |=> (ap_enable && ap_mask == $past(wr_mask)));
endmodule

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
#(
  parameter int          PKT_AW  = 8,
  parameter int          RPL_AW  = 9,
  parameter int          MAX_PAY = 252,
  parameter logic [7:0]  AP_KEY0 = 8'h00,
  parameter logic [7:0]  AP_KEY1 = 8'h86,
  parameter int          AP_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic [PKT_AW:0]   pkt_len,
  input  logic              host_busy,
  output logic [PKT_AW-1:0] pkt_raddr,
  input  logic [7:0]        pkt_rdata,
  output logic              txn_valid,
  output logic [7:0]        txn_data,
  output logic              txn_last,
  input  logic              res_valid,
  input  logic [7:0]        res_data,
  input  logic              res_done,
  input  logic [7:0]        res_len,
  output logic              rpl_we,
  output logic [RPL_AW-1:0] rpl_waddr,
  output logic [7:0]        rpl_wdata,
  output logic [RPL_AW-1:0] rpl_size,
  output logic              rpl_ready,
  output logic              ap_wr,
  output logic [15:0]       ap_wr_mask
);
  localparam int LW = PKT_AW + 1;
  localparam int EW = PKT_AW + 2;
  localparam int RPL_DEPTH = 1 << RPL_AW;
  localparam logic [RPL_AW-1:0] CNT_CAP = RPL_AW'(RPL_DEPTH - 2);

  rrf_state_e      st_q;
  logic            pend_q;
  logic [LW-1:0]   pend_len_q, len_q, ptr_q;
  logic [7:0]      b0_q, b1_q, b2_q, b3_q, rlen_q;
  logic [RPL_AW-1:0] cnt_q;

  logic is_ap, bad_req, ptr_last;
  assign is_ap    = (b0_q == AP_KEY0) && (b1_q == AP_KEY1);
  assign bad_req  = (len_q < LW'(3)) ||
                    ((EW'(b2_q) + EW'(3)) > EW'(len_q)) ||
                    (int'(b2_q) > MAX_PAY);
  assign ptr_last = ((ptr_q + LW'(1)) == len_q);

  always_comb begin
    pkt_raddr = '0;
    case (st_q)
      ST_H1:          pkt_raddr = PKT_AW'(1);
      ST_H2:          pkt_raddr = PKT_AW'(2);
      ST_H3, ST_TX0:  pkt_raddr = PKT_AW'(3);
      ST_TXB:         pkt_raddr = PKT_AW'(ptr_q + LW'(1));
      default:        pkt_raddr = '0;
    endcase
  end

  always_comb begin
    rpl_we    = 1'b0;
    rpl_waddr = '0;
    rpl_wdata = '0;
    case (st_q)
      ST_WAIT: if (res_valid && cnt_q < CNT_CAP) begin
        rpl_we    = 1'b1;
        rpl_waddr = cnt_q + RPL_AW'(2);
        rpl_wdata = res_data;
      end
      ST_HD0: begin
        rpl_we    = 1'b1;
        rpl_wdata = OK_MARK;
      end
      ST_HD1: begin
        rpl_we    = 1'b1;
        rpl_waddr = RPL_AW'(1);
        rpl_wdata = rlen_q;
      end
      ST_FAIL: begin
        rpl_we    = 1'b1;
        rpl_wdata = FAIL_MARK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      len_q      <= '0;
      ptr_q      <= '0;
      b0_q       <= '0;
      b1_q       <= '0;
      b2_q       <= '0;
      b3_q       <= '0;
      rlen_q     <= '0;
      cnt_q      <= '0;
      txn_valid  <= 1'b0;
      txn_data   <= '0;
      txn_last   <= 1'b0;
      rpl_size   <= '0;
      rpl_ready  <= 1'b0;
      ap_wr      <= 1'b0;
      ap_wr_mask <= '0;
    end else begin
      txn_valid <= 1'b0;
      txn_last  <= 1'b0;
      rpl_ready <= 1'b0;
      ap_wr     <= 1'b0;
      case (st_q)
        ST_IDLE: if (pend_q && !host_busy) begin
          pend_q <= 1'b0;
          len_q  <= pend_len_q;
          if (pend_len_q >= LW'(2)) st_q <= ST_H0;
        end
        ST_H0: st_q <= ST_H1;
        ST_H1: begin b0_q <= pkt_rdata; st_q <= ST_H2; end
        ST_H2: begin b1_q <= pkt_rdata; st_q <= ST_H3; end
        ST_H3: begin b2_q <= pkt_rdata; st_q <= ST_H4; end
        ST_H4: begin b3_q <= pkt_rdata; st_q <= ST_DEC; end
        ST_DEC: begin
          if (is_ap) begin
            if (len_q == LW'(AP_LEN)) begin
              ap_wr      <= 1'b1;
              ap_wr_mask <= {b2_q, b3_q};
            end
            st_q <= ST_IDLE;
          end else if (bad_req) begin
            st_q <= ST_FAIL;
          end else begin
            st_q <= ST_TX0;
          end
        end
        ST_TX0: begin
          txn_valid <= 1'b1;
          txn_data  <= b0_q;
          txn_last  <= (len_q == LW'(3));
          ptr_q     <= LW'(3);
          cnt_q     <= '0;
          st_q      <= (len_q == LW'(3)) ? ST_WAIT : ST_TXB;
        end
        ST_TXB: begin
          txn_valid <= 1'b1;
          txn_data  <= pkt_rdata;
          txn_last  <= ptr_last;
          ptr_q     <= ptr_q + LW'(1);
          if (ptr_last) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (res_valid) cnt_q <= cnt_q + RPL_AW'(1);
          if (res_done) begin
            rlen_q <= res_len;
            st_q   <= (res_len != 8'd0) ? ST_HD0 : ST_FAIL;
          end
        end
        ST_HD0: st_q <= ST_HD1;
        ST_HD1: begin
          rpl_size <= RPL_AW'(rlen_q) + RPL_AW'(2);
          st_q     <= ST_FIN;
        end
        ST_FAIL: begin
          rpl_size <= RPL_AW'(1);
          st_q     <= ST_FIN;
        end
        ST_FIN: begin
          rpl_ready <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (pkt_start) begin
        pend_q     <= 1'b1;
        pend_len_q <= pkt_len;
      end
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && host_busy) |=> (st_q == ST_IDLE));

  // R2
  ap_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ap_wr |-> (!txn_valid && !rpl_ready));
endmodule

// File: rtl/bus_reply_fmt.sv
module bus_reply_fmt #(
  parameter int PKT_AW  = 8,
  parameter int RPL_AW  = 9,
  parameter int MAX_PAY = 252
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_we,
  input  logic [PKT_AW-1:0] pkt_waddr,
  input  logic [7:0]        pkt_wdata,
  input  logic [PKT_AW:0]   pkt_len,
  input  logic              pkt_start,
  input  logic              host_busy,
  output logic              txn_valid,
  output logic [7:0]        txn_data,
  output logic              txn_last,
  input  logic              res_valid,
  input  logic [7:0]        res_data,
  input  logic              res_done,
  input  logic [7:0]        res_len,
  input  logic [RPL_AW-1:0] rpl_raddr,
  output logic [7:0]        rpl_rdata,
  output logic [RPL_AW-1:0] rpl_size,
  output logic              rpl_ready,
  output logic [15:0]       ap_mask,
  output logic              ap_enable,
  output logic              poll_run
);
  logic [PKT_AW-1:0] pkt_raddr;
  logic [7:0]        pkt_rdata;
  logic              rpl_we;
  logic [RPL_AW-1:0] rpl_waddr;
  logic [7:0]        rpl_wdata;
  logic              ap_wr;
  logic [15:0]       ap_wr_mask;

  rrf_ram #(.DW(8), .AW(PKT_AW)) u_pkt_ram (
    .clk(clk), .we(pkt_we), .waddr(pkt_waddr), .wdata(pkt_wdata),
    .raddr(pkt_raddr), .rdata(pkt_rdata)
  );

  rrf_ram #(.DW(8), .AW(RPL_AW)) u_rpl_ram (
    .clk(clk), .we(rpl_we), .waddr(rpl_waddr), .wdata(rpl_wdata),
    .raddr(rpl_raddr), .rdata(rpl_rdata)
  );

  rrf_ctrl #(.PKT_AW(PKT_AW), .RPL_AW(RPL_AW), .MAX_PAY(MAX_PAY)) u_ctrl (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_len(pkt_len),
    .host_busy(host_busy), .pkt_raddr(pkt_raddr), .pkt_rdata(pkt_rdata),
    .txn_valid(txn_valid), .txn_data(txn_data), .txn_last(txn_last),
    .res_valid(res_valid), .res_data(res_data), .res_done(res_done),
    .res_len(res_len), .rpl_we(rpl_we), .rpl_waddr(rpl_waddr),
    .rpl_wdata(rpl_wdata), .rpl_size(rpl_size), .rpl_ready(rpl_ready),
    .ap_wr(ap_wr), .ap_wr_mask(ap_wr_mask)
  );

  rrf_autopoll #(.MW(16)) u_autopoll (
    .clk(clk), .rst(rst), .wr(ap_wr), .wr_mask(ap_wr_mask),
    .host_busy(host_busy), .ap_mask(ap_mask), .ap_enable(ap_enable),
    .poll_run(poll_run)
  );

  // R9
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rpl_ready |=> !rpl_ready);

  // R6
  txn_last_chk: assert property (@(posedge clk) disable iff (rst)
    txn_last |-> txn_valid);

  // R10
  busy_poll_chk: assert property (@(posedge clk) disable iff (rst)
    host_busy |=> !poll_run);
endmodule

// File: tb/bus_reply_fmt_bench.sv
`timescale 1ns/1ps
module bus_reply_fmt_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pkt_we = 1'b0;
  logic [7:0] pkt_waddr = '0;
  logic [7:0] pkt_wdata = '0;
  logic [8:0] pkt_len = '0;
  logic       pkt_start = 1'b0;
  logic       host_busy = 1'b0;
  logic       txn_valid, txn_last;
  logic [7:0] txn_data;
  logic       res_valid = 1'b0;
  logic [7:0] res_data = '0;
  logic       res_done = 1'b0;
  logic [7:0] res_len = '0;
  logic [8:0] rpl_raddr = '0;
  logic [7:0] rpl_rdata;
  logic [8:0] rpl_size;
  logic       rpl_ready;
  logic [15:0] ap_mask;
  logic       ap_enable, poll_run;

  always #5 clk = ~clk;

  bus_reply_fmt u_bus_reply_fmt (
    .clk(clk), .rst(rst), .pkt_we(pkt_we), .pkt_waddr(pkt_waddr),
    .pkt_wdata(pkt_wdata), .pkt_len(pkt_len), .pkt_start(pkt_start),
    .host_busy(host_busy), .txn_valid(txn_valid), .txn_data(txn_data),
    .txn_last(txn_last), .res_valid(res_valid), .res_data(res_data),
    .res_done(res_done), .res_len(res_len), .rpl_raddr(rpl_raddr),
    .rpl_rdata(rpl_rdata), .rpl_size(rpl_size), .rpl_ready(rpl_ready),
    .ap_mask(ap_mask), .ap_enable(ap_enable), .poll_run(poll_run)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] pbuf [256];
  int plen;

  // row: len[71:64] bytes0..5[63:16] result_len[15:8] expected_size[7:0] (0 = no event)
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h05, 48'h0501_02AA_BB00, 8'h03, 8'h05},
    {8'h04, 48'h0702_01CC_0000, 8'h00, 8'h01},
    {8'h04, 48'h0702_02CC_0000, 8'h02, 8'h01},
    {8'h03, 48'h0900_0000_0000, 8'h01, 8'h03},
    {8'h02, 48'h0900_0000_0000, 8'h00, 8'h01},
    {8'h01, 48'h4400_0000_0000, 8'h00, 8'h00},
    {8'h06, 48'h0301_0311_2233, 8'h02, 8'h04},
    {8'h00, 48'h0000_0000_0000, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input int rlen, input int exp_size, input int busy_hold, input string req);
    bit fwd, got, seen_last;
    int tcnt, prev_size, exp_b;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      pkt_we = 1'b1; pkt_waddr = 8'(i); pkt_wdata = pbuf[i];
    end
    @(negedge clk);
    pkt_we = 1'b0;
    fwd = (plen >= 3) && !(pbuf[0] == 8'h00 && pbuf[1] == 8'h86) &&
          (int'(pbuf[2]) + 3 <= plen) && (int'(pbuf[2]) <= 252);
    prev_size = int'(rpl_size);
    pkt_len = 9'(plen); pkt_start = 1'b1;
    if (busy_hold > 0) host_busy = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    got = 1'b0; seen_last = 1'b0; tcnt = 0;
    if (busy_hold > 0) begin
      for (int c = 0; c < busy_hold; c++) begin
        @(negedge clk);
        if (txn_valid || rpl_ready) got = 1'b1;
      end
      chk(!got, "R10 held while busy", int'(got), 0);
      host_busy = 1'b0;
    end
    for (int c = 0; c < 700 && !got; c++) begin
      @(negedge clk);
      if (rpl_ready) got = 1'b1;
      if (txn_valid) begin
        exp_b = (tcnt == 0) ? int'(pbuf[0]) : int'(pbuf[tcnt + 2]);
        if (int'(txn_data) != exp_b) chk(1'b0, "R6 txn byte", int'(txn_data), exp_b);
        tcnt++;
        if (txn_last) begin
          seen_last = 1'b1;
          for (int k = 0; k < rlen; k++) begin
            @(negedge clk);
            res_valid = 1'b1; res_data = 8'(8'hA0 + k);
          end
          @(negedge clk);
          res_valid = 1'b0; res_done = 1'b1; res_len = 8'(rlen);
          @(negedge clk);
          res_done = 1'b0;
        end
      end
    end
    if (exp_size == 0) begin
      chk(!got, {req, " no reply event"}, int'(got), 0);
      chk(int'(rpl_size) == prev_size, {req, " size kept"}, int'(rpl_size), prev_size);
      chk(tcnt == 0, {req, " nothing forwarded"}, tcnt, 0);
    end else begin
      chk(got, "R9 reply event", int'(got), 1);
      chk(int'(rpl_size) == exp_size, {req, " reply size"}, int'(rpl_size), exp_size);
      chk(tcnt == (fwd ? plen - 2 : 0), "R6 txn count", tcnt, fwd ? plen - 2 : 0);
      chk(seen_last == fwd, "R6 txn_last", int'(seen_last), int'(fwd));
      for (int a = 0; a < exp_size; a++) begin
        @(negedge clk);
        rpl_raddr = 9'(a);
        @(negedge clk);
        if (exp_size == 1) exp_b = 8'h00;
        else if (a == 0) exp_b = 8'h01;
        else if (a == 1) exp_b = rlen;
        else exp_b = 8'hA0 + a - 2;
        chk(int'(rpl_rdata) == exp_b, (exp_size == 1) ? "R8 reply byte" : "R7 reply byte",
            int'(rpl_rdata), exp_b);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) pbuf[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset values
    chk(rpl_size == 0 && rpl_ready == 0 && txn_valid == 0, "R11 reply reset", int'(rpl_size), 0);
    chk(ap_mask == 0 && ap_enable == 0 && poll_run == 0, "R11 autopoll reset", int'(ap_mask), 0);

    // table walk: R1 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      plen = int'(VEC[v][71:64]);
      for (int b = 0; b < 6; b++) pbuf[b] = VEC[v][63 - 8*b -: 8];
      run_req(int'(VEC[v][15:8]), int'(VEC[v][7:0]), 0,
              (VEC[v][7:0] == 0) ? "R1" : "R5");
    end

    // R2 R4 autopoll load
    plen = 4; pbuf[0] = 8'h00; pbuf[1] = 8'h86; pbuf[2] = 8'h12; pbuf[3] = 8'h34;
    run_req(0, 0, 0, "R2");
    chk(ap_mask == 16'h1234, "R2 mask value", int'(ap_mask), 16'h1234);
    chk(ap_enable && poll_run, "R4 enable set", int'(poll_run), 1);
    // R10 host busy holds polling
    @(negedge clk); host_busy = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!poll_run, "R10 poll held", int'(poll_run), 0);
    host_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(poll_run, "R10 poll resumes", int'(poll_run), 1);

    // R3 wrong length autopoll form
    plen = 5; pbuf[2] = 8'h55; pbuf[3] = 8'h66; pbuf[4] = 8'h77;
    run_req(0, 0, 0, "R3");
    chk(ap_mask == 16'h1234 && ap_enable, "R3 mask kept", int'(ap_mask), 16'h1234);

    // R4 zero mask
    plen = 4; pbuf[2] = 8'h00; pbuf[3] = 8'h00;
    run_req(0, 0, 0, "R4");
    chk(!ap_enable && ap_mask == 16'h1234, "R4 zero mask", int'(ap_enable), 0);

    // R5 payload count above 252
    plen = 256;
    for (int i = 0; i < 256; i++) pbuf[i] = 8'(i);
    pbuf[0] = 8'h21; pbuf[1] = 8'h01; pbuf[2] = 8'd253;
    run_req(1, 1, 0, "R5");

    // R10 deferred start
    plen = 5; pbuf[0] = 8'h05; pbuf[1] = 8'h01; pbuf[2] = 8'h02;
    pbuf[3] = 8'hAA; pbuf[4] = 8'hBB;
    run_req(1, 3, 20, "R10");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule